// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a processor core and decides which interrupt the core should service next. It tracks sixteen interrupt numbers. Number 0 is reset and is served by the block's own reset input. Number 1 is the non-maskable interrupt. Numbers 4 to 15 are maskable: 4 to 7 come from external pins, and 8 to 15 come from on-chip source lines. Numbers 2 and 3 are unused.

Each external pin passes through a synchronizer and then an edge detector. The active edge of each pin can be inverted by a per-pin polarity bit. A pin can set its pending flag only while its GPIO enable bit is 1 and its GPIO direction bit is 0. Pending flags are sticky. They are cleared in two ways: by a write-one-to-clear register, or by the core accepting the interrupt.

The block picks the lowest-numbered request that may be serviced. It offers that request to the core as a valid/ready transfer whose payload is the interrupt number and the vector address. When the core accepts, the block saves the core's PC and updates the enable state. Return pulses from the core undo that enable change. Software reaches the block's state through a plain register port that selects one register per cycle. Writes take effect at the next clock edge. Reads are combinational.

Offer channel rules: `irq_valid` is high in every cycle in which some request qualifies. The core takes the offer in any cycle where `irq_ready` is also high. The core may hold `irq_ready` low for as long as it likes, and the pending flag stays set while it does. The payload is not frozen while the core waits. The number and vector follow the current best request, so the payload can change when a higher-priority request arrives. It can also change, or `irq_valid` can drop, when software clears a flag or disables a source.

Top module: `vic_core`

## Requirements
- R1: An external pin sets its pending flag exactly once for each active edge. The active edge is low-to-high when the pin's polarity bit is 0 and high-to-low when the bit is 1. The opposite edge sets nothing.
- R2: An external pin can set its flag only when its GPIO enable bit (register 6, bit i for pin i) is 1 and its direction bit (register 7) is 0.
- R3: A pending flag stays set until either of two events: a 1 is written to that bit of the clear register (register 1), or the core accepts that interrupt. Writing 0 bits to the clear register has no effect. Flag i appears at bit i of register 0.
- R4: A maskable request is offered only when its flag, its enable bit (register 2, bit i), the NMI-enable bit (register 2 bit 1) and the global-enable bit (register 3 bit 0) are all 1. The NMI is offered when its flag and NMI-enable are both 1.
- R5: When several requests qualify, the lowest interrupt number is offered.
- R6: On acceptance of a maskable interrupt, the saved-enable bit (register 3 bit 1) takes the global-enable value, global-enable clears, and `core_pc` is stored in the interrupt return register (register 8, also on `irp_o`).
- R7: The vector address is the table base (register 4) with its low 10 bits cleared, plus 32 times the interrupt number.
- R8: On acceptance of the NMI, `core_pc` is stored in the NMI return register (register 9, also on `nrp_o`), global-enable and saved-enable are unchanged, and NMI-enable clears. This blocks all further offers.
- R9: NMI-enable is 0 after reset and is set by writing 1 to register 2 bit 1. Writing 0 to that bit is ignored. Register 2 bit 0 always reads 1.
- R10: A `ret_int` pulse restores global-enable from saved-enable. A `ret_nmi` pulse sets NMI-enable again.
- R11: A change of a polarity bit (register 5) that inverts the pin's current effective level counts as an active edge and sets the flag. The block does not suppress this flag.
- R12: On-chip source line j sets flag 8+j on its low-to-high transition only.
- R13: Writes to the read-only registers (flags register 0, return registers 8 and 9) are ignored. The clear register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, serves interrupt 0 |
| ext_pin | input | N_EXT | Asynchronous external request pins, interrupts 4 to 7 |
| nmi_pin | input | 1 | Asynchronous non-maskable request, rising edge |
| int_src | input | N_INT | Synchronous on-chip source lines, interrupts 8 to 15 |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select: 0 flags, 1 clear, 2 enable, 3 control, 4 base, 5 polarity, 6 GPIO enable, 7 GPIO direction, 8 return, 9 NMI return |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Selected register value |
| core_pc | input | AW | Current PC, saved when an offer is accepted |
| irq_valid | output | 1 | An interrupt is offered |
| irq_ready | input | 1 | Core accepts the offer |
| irq_num | output | 4 | Offered interrupt number |
| irq_vector | output | AW | Offered vector address |
| ret_int | input | 1 | Core returns from a maskable handler |
| ret_nmi | input | 1 | Core returns from the NMI handler |
| irp_o | output | AW | Maskable return address |
| nrp_o | output | AW | NMI return address |

## Verification
Some properties are checked on every cycle. The edge detector must produce a one-cycle pulse. A pin flag may rise only under its GPIO gating. The offered number must be the lowest qualifying request and must meet all four enable conditions. Each accept must update global-enable, saved-enable, NMI-enable and the return registers correctly. NMI-enable must stay set except at NMI entry.

Other behaviour only the bench's scenarios can show. These include inverting the active edge with the polarity bit, the spurious flag from a polarity change, and write-one-to-clear semantics. They also include the exact vector arithmetic against a chosen table base, and a full enter-and-return sequence for both the maskable and NMI paths.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_IRQ        = 16;
  localparam int NMI_IDX        = 1;
  localparam int FIRST_MASKABLE = 4;

  typedef enum logic [3:0] {
    SEL_FLAGS  = 4'd0,
    SEL_CLEAR  = 4'd1,
    SEL_ENABLE = 4'd2,
    SEL_CTRL   = 4'd3,
    SEL_BASE   = 4'd4,
    SEL_POL    = 4'd5,
    SEL_GPEN   = 4'd6,
    SEL_GPDIR  = 4'd7,
    SEL_IRP    = 4'd8,
    SEL_NRP    = 4'd9
  } reg_sel_e;
endpackage

// File: rtl/vic_pin_edge.sv
module vic_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic invert,
  input  logic allow,
  output logic pulse
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   level;
  logic                   level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      level_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], pin};
      level_q <= level;
    end
  end

  // effective level: polarity applied before edge detection
  assign level = sync_q[SYNC_STAGES-1] ^ invert;
  assign pulse = allow & level & ~level_q;

  AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R1
endmodule

// File: rtl/vic_flags.sv
module vic_flags #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;

  for (genvar i = 0; i < N; i++) begin : g_hold
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q[i] && !clr_i[i] |=> flags_q[i]); // R3
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        idx   = i[IW-1:0];
      end
    end
  end

  always_comb begin
    if (valid) begin
      AST_PRIO_HIT: assert (req[idx]); // R5
      AST_PRIO_LOWEST: assert ((req & ((N'(1) << idx) - N'(1))) == '0); // R5
    end
  end
endmodule

// File: rtl/vic_core.sv
module vic_core import vic_pkg::*; #(
  parameter int N_EXT       = 4,
  parameter int N_INT       = 8,
  parameter int AW          = 32,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_SHIFT   = 5,
  parameter int ALIGN_BITS  = 10,
  localparam int NUM        = FIRST_MASKABLE + N_EXT + N_INT,
  localparam int IW         = $clog2(NUM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic             nmi_pin,
  input  logic [N_INT-1:0] int_src,
  input  logic             reg_wr,
  input  logic [3:0]       reg_sel,
  input  logic [AW-1:0]    reg_wdata,
  output logic [AW-1:0]    reg_rdata,
  input  logic [AW-1:0]    core_pc,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [IW-1:0]    irq_num,
  output logic [AW-1:0]    irq_vector,
  input  logic             ret_int,
  input  logic             ret_nmi,
  output logic [AW-1:0]    irp_o,
  output logic [AW-1:0]    nrp_o
);
  localparam int EXT_BASE = FIRST_MASKABLE;
  localparam int INT_BASE = EXT_BASE + N_EXT;
  localparam logic [NUM-1:0] MASKABLE =
    {{(NUM-FIRST_MASKABLE){1'b1}}, {FIRST_MASKABLE{1'b0}}};
  localparam logic [NUM-1:0] NMI_BIT = NUM'(1) << NMI_IDX;

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel);

  logic             wr_clear, wr_enable, wr_ctrl, wr_base, wr_pol, wr_gpen, wr_gpdir;
  logic [NUM-1:0]   en_q;
  logic             nmie_q, gie_q, pgie_q;
  logic [AW-1:0]    base_q, irp_q, nrp_q;
  logic [N_EXT-1:0] pol_q, gpen_q, gpdir_q;
  logic [N_EXT-1:0] ext_pulse;
  logic             nmi_pulse;
  logic [N_INT-1:0] src_q, src_rise;
  logic [NUM-1:0]   set_vec, clr_vec, flags, req;
  logic             take, take_nmi, take_msk;

  assign wr_clear  = reg_wr && (sel == SEL_CLEAR);
  assign wr_enable = reg_wr && (sel == SEL_ENABLE);
  assign wr_ctrl   = reg_wr && (sel == SEL_CTRL);
  assign wr_base   = reg_wr && (sel == SEL_BASE);
  assign wr_pol    = reg_wr && (sel == SEL_POL);
  assign wr_gpen   = reg_wr && (sel == SEL_GPEN);
  assign wr_gpdir  = reg_wr && (sel == SEL_GPDIR);

  // external pins: synchronize, apply polarity, gate by GPIO mode
  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    vic_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin    (ext_pin[i]),
      .invert (pol_q[i]),
      .allow  (gpen_q[i] & ~gpdir_q[i]),
      .pulse  (ext_pulse[i])
    );
  end

  vic_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_nmi_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (nmi_pin),
    .invert (1'b0),
    .allow  (1'b1),
    .pulse  (nmi_pulse)
  );

  // on-chip sources are synchronous: rising edge only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= int_src;
  end
  assign src_rise = int_src & ~src_q;

  always_comb begin
    set_vec                        = '0;
    set_vec[NMI_IDX]               = nmi_pulse;
    set_vec[EXT_BASE +: N_EXT]     = ext_pulse;
    set_vec[INT_BASE +: N_INT]     = src_rise;
  end

  assign clr_vec = (wr_clear ? reg_wdata[NUM-1:0] : '0)
                 | (take ? (NUM'(1) << irq_num) : '0);

  vic_flags #(.N(NUM)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flags)
  );

  // qualification: four-way AND for maskables, NMI-enable for the NMI
  assign req = (flags & en_q & {NUM{gie_q & nmie_q}})
             | (flags & NMI_BIT & {NUM{nmie_q}});

  vic_prio #(.N(NUM), .IW(IW)) u_prio (
    .req   (req),
    .valid (irq_valid),
    .idx   (irq_num)
  );

  assign irq_vector = {base_q[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}}
                    + (AW'(irq_num) << VEC_SHIFT);

  assign take     = irq_valid & irq_ready;
  assign take_nmi = take & (irq_num == IW'(NMI_IDX));
  assign take_msk = take & ~take_nmi;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      base_q  <= '0;
      pol_q   <= '0;
      gpen_q  <= '0;
      gpdir_q <= '0;
    end else begin
      if (wr_enable) en_q    <= reg_wdata[NUM-1:0] & MASKABLE;
      if (wr_base)   base_q  <= reg_wdata;
      if (wr_pol)    pol_q   <= reg_wdata[N_EXT-1:0];
      if (wr_gpen)   gpen_q  <= reg_wdata[N_EXT-1:0];
      if (wr_gpdir)  gpdir_q <= reg_wdata[N_EXT-1:0];
    end
  end

  // enable state machine: entry beats return beats software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmie_q <= 1'b0;
      gie_q  <= 1'b0;
      pgie_q <= 1'b0;
    end else begin
      if (take_nmi)                             nmie_q <= 1'b0;
      else if (ret_nmi)                         nmie_q <= 1'b1;
      else if (wr_enable && reg_wdata[NMI_IDX]) nmie_q <= 1'b1;

      if (take_msk) begin
        pgie_q <= gie_q;
        gie_q  <= 1'b0;
      end else if (ret_int) begin
        gie_q  <= pgie_q;
      end else if (wr_ctrl) begin
        gie_q  <= reg_wdata[0];
        pgie_q <= reg_wdata[1];
      end
    end
  end

  // return address registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irp_q <= '0;
      nrp_q <= '0;
    end else begin
      if (take_msk) irp_q <= core_pc;
      if (take_nmi) nrp_q <= core_pc;
    end
  end

  assign irp_o = irp_q;
  assign nrp_o = nrp_q;

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_FLAGS:  reg_rdata = AW'(flags);
      SEL_ENABLE: reg_rdata = AW'(en_q | (NUM'(nmie_q) << NMI_IDX) | NUM'(1));
      SEL_CTRL:   reg_rdata = AW'({pgie_q, gie_q});
      SEL_BASE:   reg_rdata = base_q;
      SEL_POL:    reg_rdata = AW'(pol_q);
      SEL_GPEN:   reg_rdata = AW'(gpen_q);
      SEL_GPDIR:  reg_rdata = AW'(gpdir_q);
      SEL_IRP:    reg_rdata = irp_q;
      SEL_NRP:    reg_rdata = nrp_q;
      default:    reg_rdata = '0;
    endcase
  end

  // properties guarding the core-side sequencing
  for (genvar i = 0; i < N_EXT; i++) begin : g_gate_chk
    AST_GPIO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[EXT_BASE+i]) |-> $past(gpen_q[i] && !gpdir_q[i])); // R2
  end

  AST_OFFER_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && (irq_num != IW'(NMI_IDX)) |->
      gie_q && nmie_q && en_q[irq_num] && flags[irq_num]); // R4

  AST_VECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vector[VEC_SHIFT-1:0] == '0); // R7

  AST_MSK_ENTRY_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take_msk |=> !gie_q && (pgie_q == $past(gie_q))); // R6

  AST_MSK_ENTRY_PC: assert property (@(posedge clk) disable iff (!rst_n)
    take_msk |=> irp_q == $past(core_pc)); // R6

  AST_NMI_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi && !wr_ctrl && !ret_int |=>
      !nmie_q && $stable(gie_q) && $stable(pgie_q) && (nrp_q == $past(core_pc))); // R8

  AST_NMIE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    nmie_q && !take_nmi |=> nmie_q); // R9
endmodule

// File: tb/vic_core_tb.sv
module vic_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ext_pin = '0;
  logic        nmi_pin = 1'b0;
  logic [7:0]  int_src = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] core_pc = '0;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [3:0]  irq_num;
  logic [31:0] irq_vector;
  logic        ret_int = 1'b0;
  logic        ret_nmi = 1'b0;
  logic [31:0] irp_o, nrp_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  vic_core u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .nmi_pin(nmi_pin),
    .int_src(int_src), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_pc(core_pc),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_num(irq_num),
    .irq_vector(irq_vector), .ret_int(ret_int), .ret_nmi(ret_nmi),
    .irp_o(irp_o), .nrp_o(nrp_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      fails = fails + 1;
      $display("FAIL watchdog (all R): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] s, input logic [31:0] exp);
    @(negedge clk);
    reg_sel = s;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic offer_chk(input string tag, input logic v, input logic [3:0] n);
    @(negedge clk);
    #1;
    chk({tag, " valid"}, 32'(irq_valid), 32'(v));
    if (v) chk({tag, " num"}, 32'(irq_num), 32'(n));
  endtask

  task automatic take(input logic [31:0] pc);
    @(negedge clk);
    core_pc = pc; irq_ready = 1'b1;
    @(negedge clk);
    irq_ready = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R3 reset flags", 4'd0, 32'h0);
    rd_chk("R9 reset enable", 4'd2, 32'h1);
    rd_chk("R6 reset ctrl", 4'd3, 32'h0);
    offer_chk("R4 reset offer", 1'b0, 4'd0);
  endtask

  task automatic t_rise_default;
    wr(4'd6, 32'hF);
    wr(4'd7, 32'h0);
    @(negedge clk) ext_pin[0] = 1'b1;
    idle(4);
    rd_chk("R1 rising edge sets flag 4", 4'd0, 32'h10);
    @(negedge clk) ext_pin[0] = 1'b0;
    idle(4);
    rd_chk("R1 falling edge ignored", 4'd0, 32'h10);
    wr(4'd1, 32'h0);
    rd_chk("R3 clear with zeros", 4'd0, 32'h10);
    wr(4'd0, 32'hFFFF);
    rd_chk("R13 flags write ignored", 4'd0, 32'h10);
    rd_chk("R13 clear reads zero", 4'd1, 32'h0);
    wr(4'd1, 32'h10);
    rd_chk("R3 clear with one", 4'd0, 32'h0);
  endtask

  task automatic t_polarity;
    wr(4'd5, 32'h2);
    idle(3);
    rd_chk("R11 polarity flip sets flag 5", 4'd0, 32'h20);
    wr(4'd1, 32'h20);
    @(negedge clk) ext_pin[1] = 1'b1;
    idle(4);
    rd_chk("R1 inverted: rising ignored", 4'd0, 32'h0);
    @(negedge clk) ext_pin[1] = 1'b0;
    idle(4);
    rd_chk("R1 inverted: falling sets", 4'd0, 32'h20);
    wr(4'd1, 32'h20);
    wr(4'd5, 32'h0);
    idle(3);
    rd_chk("R11 restoring polarity at low level", 4'd0, 32'h0);
  endtask

  task automatic t_gating;
    wr(4'd6, 32'hB);
    @(negedge clk) ext_pin[2] = 1'b1;
    idle(4);
    rd_chk("R2 GPIO disabled blocks", 4'd0, 32'h0);
    @(negedge clk) ext_pin[2] = 1'b0;
    wr(4'd6, 32'hF);
    wr(4'd7, 32'h4);
    idle(3);
    @(negedge clk) ext_pin[2] = 1'b1;
    idle(4);
    rd_chk("R2 output direction blocks", 4'd0, 32'h0);
    @(negedge clk) ext_pin[2] = 1'b0;
    idle(4);
    wr(4'd7, 32'h0);
    @(negedge clk) ext_pin[2] = 1'b1;
    idle(4);
    rd_chk("R2 enabled input sets flag 6", 4'd0, 32'h40);
    @(negedge clk) ext_pin[2] = 1'b0;
    idle(4);
    wr(4'd1, 32'h40);
  endtask

  task automatic t_internal;
    @(negedge clk) int_src[2] = 1'b1;
    idle(2);
    rd_chk("R12 source rise sets flag 10", 4'd0, 32'h400);
    @(negedge clk) int_src[2] = 1'b0;
    idle(2);
    rd_chk("R12 source fall no change", 4'd0, 32'h400);
  endtask

  task automatic t_qualify;
    wr(4'd2, 32'h400);
    wr(4'd3, 32'h1);
    offer_chk("R4 NMI-enable low blocks", 1'b0, 4'd0);
    wr(4'd2, 32'h402);
    rd_chk("R9 NMI-enable set by write", 4'd2, 32'h403);
    offer_chk("R4 all four conditions", 1'b1, 4'd10);
    wr(4'd3, 32'h0);
    offer_chk("R4 global-enable low blocks", 1'b0, 4'd0);
    wr(4'd3, 32'h1);
  endtask

  task automatic t_priority;
    @(negedge clk) begin int_src[4] = 1'b1; ext_pin[3] = 1'b1; end
    idle(4);
    @(negedge clk) begin int_src[4] = 1'b0; ext_pin[3] = 1'b0; end
    idle(4);
    rd_chk("R3 three flags pending", 4'd0, 32'h1480);
    offer_chk("R5 disabled sources not offered", 1'b1, 4'd10);
    wr(4'd2, 32'h1482);
    offer_chk("R5 lowest number wins", 1'b1, 4'd7);
    wr(4'd4, 32'h1234_5678);
    @(negedge clk);
    #1 chk("R7 vector for 7", irq_vector, 32'h1234_54E0);
  endtask

  task automatic t_take_return;
    take(32'hCAFE_0100);
    rd_chk("R6 ctrl after entry", 4'd3, 32'h2);
    rd_chk("R6 return register", 4'd8, 32'hCAFE_0100);
    chk("R6 irp_o", irp_o, 32'hCAFE_0100);
    rd_chk("R3 taken flag cleared", 4'd0, 32'h1400);
    offer_chk("R4 nothing offered in handler", 1'b0, 4'd0);
    wr(4'd8, 32'h0);
    rd_chk("R13 return register write ignored", 4'd8, 32'hCAFE_0100);
    @(negedge clk) ret_int = 1'b1;
    @(negedge clk) ret_int = 1'b0;
    rd_chk("R10 global-enable restored", 4'd3, 32'h3);
    offer_chk("R5 next request offered", 1'b1, 4'd10);
    @(negedge clk);
    #1 chk("R7 vector for 10", irq_vector, 32'h1234_5540);
  endtask

  task automatic t_nmi;
    wr(4'd2, 32'h1480);
    rd_chk("R9 write of zero ignored", 4'd2, 32'h1483);
    @(negedge clk) nmi_pin = 1'b1;
    idle(4);
    offer_chk("R5 NMI beats maskables", 1'b1, 4'd1);
    @(negedge clk);
    #1 chk("R7 vector for NMI", irq_vector, 32'h1234_5420);
    take(32'hBEEF_0020);
    rd_chk("R8 NMI return register", 4'd9, 32'hBEEF_0020);
    chk("R8 nrp_o", nrp_o, 32'hBEEF_0020);
    rd_chk("R8 enables unchanged", 4'd3, 32'h3);
    rd_chk("R8 NMI-enable cleared", 4'd2, 32'h1481);
    offer_chk("R8 all offers blocked", 1'b0, 4'd0);
    rd_chk("R3 NMI flag cleared", 4'd0, 32'h1400);
    @(negedge clk) ret_nmi = 1'b1;
    @(negedge clk) ret_nmi = 1'b0;
    rd_chk("R10 NMI-enable restored", 4'd2, 32'h1483);
    offer_chk("R10 offers resume", 1'b1, 4'd10);
    @(negedge clk) nmi_pin = 1'b0;
    wr(4'd1, 32'hFFFF);
    rd_chk("R3 clear all", 4'd0, 32'h0);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_rise_default();
    t_polarity();
    t_gating();
    t_internal();
    t_qualify();
    t_priority();
    t_take_return();
    t_nmi();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule